// File: doc/BRIEF.md
# Hardware-Monitor Limit Check and Interrupt Unit

This block takes one measurement at a time, tagged with a slot number, and checks it against limits that software has programmed. It covers seven voltage channels, one temperature channel and three fan-tachometer counts. Any result outside its limits sets a sticky bit in a pair of 8-bit status registers. Three external event lines also set status bits after they are synchronised and edge-detected: a chained system-management interrupt, a board temperature alarm and a chassis intrusion switch.

The block drives two interrupt outputs, `smi_o` and `nmi_o`. Each output has its own per-source mask set, a block bit that silences the whole output, and an enable bit. Software reads a status byte to collect events. The read clears exactly the bits it returned. The measurement sequencer and the ADC sit outside the block and present results on a valid/index/data interface.

Top module: `hwmon_irq_unit`

## Requirements
- R1: After reset:
  - both status bytes, both mask sets and the control register read 0, and both outputs are low;
  - each voltage high limit reads 0xFF and each voltage low limit reads 0x00;
  - both temperature limits read 0x7F and each fan limit reads 0xFF.
- R2: A voltage measurement (slot 0..6) sets bit n of status byte 0x00, where n is the slot number, when the value is strictly above that channel's high limit or strictly below its low limit. The comparison is unsigned. The bit reads back on the first clock after the cycle in which `meas_valid_i` was high.
- R3: Temperature (slot 7) is compared as signed two's complement and uses hysteresis:
  - a value above the over-limit enters the hot state;
  - a value below the hysteresis limit leaves the hot state;
  - any other value keeps the current state;
  - every temperature measurement that leaves the block in the hot state sets bit 7 of byte 0x00.
- R4: A fan measurement (slot 8+f, f=0..2) sets bit f of status byte 0x01 when the count is strictly above that fan's limit.
- R5: Status bits are sticky. A read strobe at 0x00 or 0x01 clears only the bits of that byte that were returned by that read. A bit that is set in the same cycle as the read stays set. Reading one byte leaves the other byte unchanged.
- R6: External events set bits in byte 0x01 on a rising edge of the input, and the bit reads back on the third rising clock after the input goes high:
  - the chained SMI input sets bit 3;
  - the board temperature input sets bit 4;
  - the chassis intrusion input sets bit 5.
  A level that stays high does not set the bit again after it has been cleared.
- R7: Mask bit k at 0x02/0x03 (SMI) and at 0x04/0x05 (NMI) set to 1 removes status bit k from that output only. Status bit k is bit k%8 of byte 0x00+k/8.
- R8: The control register at 0x06 has four bits:
  - bit0 enables `smi_o` and bit1 enables `nmi_o`;
  - bit2 blocks `smi_o` and bit3 blocks `nmi_o`.
  An output is high only when it is enabled, not blocked, and at least one of its unmasked status bits is set.
- R9: Writes to the status bytes have no effect. A measurement whose slot is 11 or higher has no effect. Status and mask bits 14 and 15 and control bits 7..4 read as 0.
- R10: Limits are readable and writable at these addresses:
  - voltage channel i: high limit at 0x10+2i, low limit at 0x11+2i;
  - temperature: over-limit at 0x1E, hysteresis limit at 0x1F;
  - fan f: limit at 0x20+f.
  Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_valid_i | input | 1 | Measurement present this cycle |
| meas_idx_i | input | 4 | Slot number of the measurement |
| meas_data_i | input | 8 | Measured value |
| smi_chain_i | input | 1 | Chained SMI event, rising edge active |
| board_temp_i | input | 1 | Board temperature alarm, rising edge active |
| intrusion_i | input | 1 | Chassis intrusion, rising edge active |
| reg_addr_i | input | 6 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status on read) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| smi_o | output | 1 | SMI interrupt output |
| nmi_o | output | 1 | NMI/IRQ interrupt output |

## Verification
Voltage values are applied exactly at each limit and one step beyond it, which separates a strict comparison from an inclusive one. Temperature values placed between the two limits, before and after the hot state is entered, show whether hysteresis is present. A negative reading shows whether the temperature compare is unsigned. A read strobe that lands in the same cycle as a new violation shows whether the clear is limited to the bits that were returned. Mask, block and enable bits are toggled one at a time with sources set in both status bytes, which shows that each output has its own gating. Event inputs are sampled one cycle before and in the cycle of the expected set, which pins the depth of the synchroniser.

// File: rtl/hwmon_irq_pkg.sv
package hwmon_irq_pkg;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int ST_W = 2 * DW;

  // register map
  localparam int A_ST_LO   = 'h00;
  localparam int A_ST_HI   = 'h01;
  localparam int A_SMSK_LO = 'h02;
  localparam int A_SMSK_HI = 'h03;
  localparam int A_NMSK_LO = 'h04;
  localparam int A_NMSK_HI = 'h05;
  localparam int A_CTL     = 'h06;
  localparam int A_LIM     = 'h10;

  // control bits
  localparam int CTL_W     = 4;
  localparam int C_SMI_EN  = 0;
  localparam int C_NMI_EN  = 1;
  localparam int C_SMI_BLK = 2;
  localparam int C_NMI_BLK = 3;
endpackage

// File: rtl/hwmon_evt_sync.sv
module hwmon_evt_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);
  for (genvar e = 0; e < N; e++) begin : g_evt
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= evt_i[e];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign rise_o[e] = s2_q & ~prev_q;

    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[e] |=> !rise_o[e]);
  end
endmodule

// File: rtl/hwmon_limit_chk.sv
module hwmon_limit_chk
  import hwmon_irq_pkg::*;
#(
  parameter int N_VOLT = 7,
  parameter int N_FAN  = 3,
  parameter int SLOT_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          meas_valid_i,
  input  logic [SLOT_W-1:0]             meas_idx_i,
  input  logic [DW-1:0]                 meas_data_i,
  input  logic [AW-1:0]                 reg_addr_i,
  input  logic                          reg_wr_i,
  input  logic [DW-1:0]                 reg_wdata_i,
  output logic [N_VOLT+N_FAN:0]         viol_o,
  output logic [DW-1:0]                 rdata_o
);
  localparam int N_LIM   = N_VOLT + 1 + N_FAN;
  localparam int T_SLOT  = N_VOLT;
  localparam int F_SLOT  = N_VOLT + 1;
  localparam int A_TOVER = A_LIM + 2 * N_VOLT;
  localparam int A_THYST = A_TOVER + 1;
  localparam int A_FAN   = A_THYST + 1;

  logic [N_VOLT-1:0][DW-1:0] vhi_rd, vlo_rd;
  logic [N_FAN-1:0][DW-1:0]  fan_rd;
  logic [DW-1:0]             tover_q, thyst_q;
  logic                      hot_q, hot_d, t_meas;

  for (genvar v = 0; v < N_VOLT; v++) begin : g_volt
    logic [DW-1:0] hi_q, lo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '1;
        lo_q <= '0;
      end else if (reg_wr_i) begin
        if (reg_addr_i == AW'(A_LIM + 2 * v))     hi_q <= reg_wdata_i;
        if (reg_addr_i == AW'(A_LIM + 2 * v + 1)) lo_q <= reg_wdata_i;
      end
    end
    assign vhi_rd[v] = hi_q;
    assign vlo_rd[v] = lo_q;
    assign viol_o[v] = meas_valid_i && (meas_idx_i == SLOT_W'(v)) &&
                       ((meas_data_i > hi_q) || (meas_data_i < lo_q));
  end

  for (genvar f = 0; f < N_FAN; f++) begin : g_fan
    logic [DW-1:0] lim_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         lim_q <= '1;
      else if (reg_wr_i && reg_addr_i == AW'(A_FAN + f))   lim_q <= reg_wdata_i;
    end
    assign fan_rd[f]          = lim_q;
    assign viol_o[F_SLOT + f] = meas_valid_i && (meas_idx_i == SLOT_W'(F_SLOT + f)) &&
                                (meas_data_i > lim_q);
  end

  // temperature: signed compare with hysteresis
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tover_q <= 8'h7f;
      thyst_q <= 8'h7f;
      hot_q   <= 1'b0;
    end else begin
      hot_q <= hot_d;
      if (reg_wr_i && reg_addr_i == AW'(A_TOVER)) tover_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == AW'(A_THYST)) thyst_q <= reg_wdata_i;
    end
  end

  assign t_meas = meas_valid_i && (meas_idx_i == SLOT_W'(T_SLOT));

  always_comb begin
    hot_d = hot_q;
    if (t_meas) begin
      if ($signed(meas_data_i) > $signed(tover_q))      hot_d = 1'b1;
      else if ($signed(meas_data_i) < $signed(thyst_q)) hot_d = 1'b0;
    end
  end
  assign viol_o[T_SLOT] = t_meas && hot_d;

  always_comb begin
    rdata_o = '0;
    for (int v = 0; v < N_VOLT; v++) begin
      if (reg_addr_i == AW'(A_LIM + 2 * v))     rdata_o = vhi_rd[v];
      if (reg_addr_i == AW'(A_LIM + 2 * v + 1)) rdata_o = vlo_rd[v];
    end
    for (int f = 0; f < N_FAN; f++)
      if (reg_addr_i == AW'(A_FAN + f)) rdata_o = fan_rd[f];
    if (reg_addr_i == AW'(A_TOVER)) rdata_o = tover_q;
    if (reg_addr_i == AW'(A_THYST)) rdata_o = thyst_q;
  end

  assert_one_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(viol_o));

  assert_hot_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t_meas |=> $stable(hot_q));

  if (N_LIM > (1 << SLOT_W)) begin : g_bad_slot_w
    initial assert_slot_width_R9: assert (0) else $error("SLOT_W too small");
  end
endmodule

// File: rtl/hwmon_irq_ctrl.sv
module hwmon_irq_ctrl
  import hwmon_irq_pkg::*;
#(
  parameter int N_SRC = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             smi_o,
  output logic             nmi_o
);
  logic [N_SRC-1:0] st_q, st_d, smsk_q, smsk_d, nmsk_q, nmsk_d;
  logic [CTL_W-1:0] ctl_q;
  logic [ST_W-1:0]  st_w, smsk_w, nmsk_w, clr_w, smsk_nw, nmsk_nw;
  logic             rd_lo, rd_hi;

  assign st_w   = ST_W'(st_q);
  assign smsk_w = ST_W'(smsk_q);
  assign nmsk_w = ST_W'(nmsk_q);
  assign rd_lo  = reg_rd_i && (reg_addr_i == AW'(A_ST_LO));
  assign rd_hi  = reg_rd_i && (reg_addr_i == AW'(A_ST_HI));

  // clear only what the read returned; new sets win
  always_comb begin
    clr_w = '0;
    if (rd_lo) clr_w[DW-1:0]    = st_w[DW-1:0];
    if (rd_hi) clr_w[ST_W-1:DW] = st_w[ST_W-1:DW];
    st_d = (st_q & ~clr_w[N_SRC-1:0]) | set_i;
  end

  always_comb begin
    smsk_nw = smsk_w;
    nmsk_nw = nmsk_w;
    if (reg_wr_i) begin
      if (reg_addr_i == AW'(A_SMSK_LO)) smsk_nw[DW-1:0]    = reg_wdata_i;
      if (reg_addr_i == AW'(A_SMSK_HI)) smsk_nw[ST_W-1:DW] = reg_wdata_i;
      if (reg_addr_i == AW'(A_NMSK_LO)) nmsk_nw[DW-1:0]    = reg_wdata_i;
      if (reg_addr_i == AW'(A_NMSK_HI)) nmsk_nw[ST_W-1:DW] = reg_wdata_i;
    end
    smsk_d = smsk_nw[N_SRC-1:0];
    nmsk_d = nmsk_nw[N_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      smsk_q <= '0;
      nmsk_q <= '0;
      ctl_q  <= '0;
    end else begin
      st_q   <= st_d;
      smsk_q <= smsk_d;
      nmsk_q <= nmsk_d;
      if (reg_wr_i && reg_addr_i == AW'(A_CTL)) ctl_q <= reg_wdata_i[CTL_W-1:0];
    end
  end

  assign smi_o = ctl_q[C_SMI_EN] & ~ctl_q[C_SMI_BLK] & (|(st_q & ~smsk_q));
  assign nmi_o = ctl_q[C_NMI_EN] & ~ctl_q[C_NMI_BLK] & (|(st_q & ~nmsk_q));

  always_comb begin
    rdata_o = '0;
    case (reg_addr_i)
      AW'(A_ST_LO):   rdata_o = st_w[DW-1:0];
      AW'(A_ST_HI):   rdata_o = st_w[ST_W-1:DW];
      AW'(A_SMSK_LO): rdata_o = smsk_w[DW-1:0];
      AW'(A_SMSK_HI): rdata_o = smsk_w[ST_W-1:DW];
      AW'(A_NMSK_LO): rdata_o = nmsk_w[DW-1:0];
      AW'(A_NMSK_HI): rdata_o = nmsk_w[ST_W-1:DW];
      AW'(A_CTL):     rdata_o = DW'(ctl_q);
      default:        rdata_o = '0;
    endcase
  end

  assert_sticky_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo |=> ((st_w[DW-1:0] & $past(st_w[DW-1:0])) == $past(st_w[DW-1:0])));

  assert_sticky_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hi |=> ((st_w[ST_W-1:DW] & $past(st_w[ST_W-1:DW])) == $past(st_w[ST_W-1:DW])));

  assert_clear_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo && ST_W'(set_i) == '0) |=> (st_w[DW-1:0] == '0));

  assert_smi_has_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> (st_q != '0));

  assert_nmi_has_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (st_q != '0));

  if (N_SRC > ST_W) begin : g_bad_src
    initial assert_src_fit_R9: assert (0) else $error("too many sources");
  end
endmodule

// File: rtl/hwmon_irq_unit.sv
module hwmon_irq_unit
  import hwmon_irq_pkg::*;
#(
  parameter int N_VOLT = 7,
  parameter int N_FAN  = 3,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              meas_valid_i,
  input  logic [SLOT_W-1:0] meas_idx_i,
  input  logic [DW-1:0]     meas_data_i,
  input  logic              smi_chain_i,
  input  logic              board_temp_i,
  input  logic              intrusion_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              smi_o,
  output logic              nmi_o
);
  localparam int N_LIM = N_VOLT + 1 + N_FAN;
  localparam int N_EXT = 3;
  localparam int N_SRC = N_LIM + N_EXT;

  logic [N_LIM-1:0] viol;
  logic [N_EXT-1:0] evt, rise;
  logic [DW-1:0]    lim_rdata, ctl_rdata;

  assign evt = {intrusion_i, board_temp_i, smi_chain_i};

  hwmon_evt_sync #(.N(N_EXT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .rise_o (rise)
  );

  hwmon_limit_chk #(.N_VOLT(N_VOLT), .N_FAN(N_FAN), .SLOT_W(SLOT_W)) u_lim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .meas_valid_i (meas_valid_i),
    .meas_idx_i   (meas_idx_i),
    .meas_data_i  (meas_data_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .viol_o       (viol),
    .rdata_o      (lim_rdata)
  );

  hwmon_irq_ctrl #(.N_SRC(N_SRC)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       ({rise, viol}),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wdata_i (reg_wdata_i),
    .rdata_o     (ctl_rdata),
    .smi_o       (smi_o),
    .nmi_o       (nmi_o)
  );

  // address ranges do not overlap; unmapped sides return 0
  assign reg_rdata_o = lim_rdata | ctl_rdata;
endmodule

// File: tb/hwmon_irq_unit_tb_top.sv
module hwmon_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       meas_valid = 1'b0;
  logic [3:0] meas_idx = '0;
  logic [7:0] meas_data = '0;
  logic       smi_chain = 1'b0, board_temp = 1'b0, intrusion = 1'b0;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       smi, nmi;
  int         n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  hwmon_irq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .meas_valid_i(meas_valid), .meas_idx_i(meas_idx), .meas_data_i(meas_data),
    .smi_chain_i(smi_chain), .board_temp_i(board_temp), .intrusion_i(intrusion),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .smi_o(smi), .nmi_o(nmi)
  );

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_clr(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic meas(logic [3:0] i, logic [7:0] d);
    @(negedge clk);
    meas_valid = 1'b1; meas_idx = i; meas_data = d;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rd_clr(6'h00, d);
    rd_clr(6'h01, d);
  endtask

  task automatic chk_out(string req, logic es, logic en);
    #1;
    chk(req, "smi_o", {7'd0, smi}, {7'd0, es});
    chk(req, "nmi_o", {7'd0, nmi}, {7'd0, en});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk_out("R1", 1'b0, 1'b0);
    peek(6'h00, d); chk("R1", "status lo", d, 8'h00);
    peek(6'h01, d); chk("R1", "status hi", d, 8'h00);
    peek(6'h03, d); chk("R1", "smi mask hi", d, 8'h00);
    peek(6'h06, d); chk("R1", "ctrl", d, 8'h00);
    peek(6'h10, d); chk("R1", "volt0 hi", d, 8'hff);
    peek(6'h11, d); chk("R1", "volt0 lo", d, 8'h00);
    peek(6'h1e, d); chk("R1", "temp over", d, 8'h7f);
    peek(6'h1f, d); chk("R1", "temp hyst", d, 8'h7f);
    peek(6'h22, d); chk("R1", "fan2 lim", d, 8'hff);
  endtask

  task automatic t_volt();
    logic [7:0] d;
    wr(6'h14, 8'hc0); wr(6'h15, 8'h40);
    peek(6'h14, d); chk("R10", "volt2 hi readback", d, 8'hc0);
    peek(6'h15, d); chk("R10", "volt2 lo readback", d, 8'h40);
    meas(4'd0, 8'hff); peek(6'h00, d); chk("R2", "default limits", d, 8'h00);
    meas(4'd2, 8'hc0); peek(6'h00, d); chk("R2", "equal high", d, 8'h00);
    meas(4'd2, 8'hc1); peek(6'h00, d); chk("R2", "above high", d, 8'h04);
    meas(4'd2, 8'h80); peek(6'h00, d); chk("R5", "sticky after ok value", d, 8'h04);
    rd_clr(6'h00, d); chk("R5", "read returns", d, 8'h04);
    peek(6'h00, d); chk("R5", "cleared", d, 8'h00);
    meas(4'd2, 8'h40); peek(6'h00, d); chk("R2", "equal low", d, 8'h00);
    meas(4'd2, 8'h3f); peek(6'h00, d); chk("R2", "below low", d, 8'h04);
    clear_all();
  endtask

  task automatic t_temp();
    logic [7:0] d;
    wr(6'h1e, 8'h32); wr(6'h1f, 8'h2d);
    meas(4'd7, 8'hf0); peek(6'h00, d); chk("R3", "negative not over", d, 8'h00);
    meas(4'd7, 8'h32); peek(6'h00, d); chk("R3", "equal over", d, 8'h00);
    meas(4'd7, 8'h33); peek(6'h00, d); chk("R3", "above over", d, 8'h80);
    clear_all();
    meas(4'd7, 8'h2e); peek(6'h00, d); chk("R3", "hot in band", d, 8'h80);
    clear_all();
    meas(4'd7, 8'h2c); peek(6'h00, d); chk("R3", "below hyst", d, 8'h00);
    meas(4'd7, 8'h2e); peek(6'h00, d); chk("R3", "cool in band", d, 8'h00);
    clear_all();
  endtask

  task automatic t_fan();
    logic [7:0] d;
    wr(6'h21, 8'h80);
    meas(4'd9, 8'h80); peek(6'h01, d); chk("R4", "fan1 equal", d, 8'h00);
    meas(4'd9, 8'h81); peek(6'h01, d); chk("R4", "fan1 above", d, 8'h02);
    peek(6'h00, d); chk("R4", "lo byte untouched", d, 8'h00);
    clear_all();
  endtask

  task automatic t_read_race();
    logic [7:0] d;
    wr(6'h16, 8'h10);
    meas(4'd3, 8'h20);
    meas(4'd2, 8'hc1);
    meas(4'd9, 8'h90);
    rd_clr(6'h01, d); chk("R5", "hi read", d, 8'h02);
    peek(6'h00, d); chk("R5", "lo kept on hi read", d, 8'h0c);
    @(negedge clk);
    meas_valid = 1'b1; meas_idx = 4'd2; meas_data = 8'hc1;
    reg_addr = 6'h00; reg_rd = 1'b1;
    #1 d = reg_rdata; chk("R5", "read in set cycle", d, 8'h0c);
    @(negedge clk);
    meas_valid = 1'b0; reg_rd = 1'b0;
    peek(6'h00, d); chk("R5", "new set survives clear", d, 8'h04);
    wr(6'h16, 8'hff);
    clear_all();
  endtask

  task automatic t_ext();
    logic [7:0] d;
    @(negedge clk);
    reg_addr = 6'h01; intrusion = 1'b1;
    @(negedge clk); @(negedge clk);
    #1 chk("R6", "intrusion after 2 clocks", reg_rdata, 8'h00);
    @(negedge clk);
    #1 chk("R6", "intrusion after 3 clocks", reg_rdata, 8'h20);
    rd_clr(6'h01, d);
    repeat (5) @(negedge clk);
    peek(6'h01, d); chk("R6", "held level no reset", d, 8'h00);
    intrusion = 1'b0;
    @(negedge clk);
    board_temp = 1'b1;
    @(negedge clk);
    board_temp = 1'b0;
    repeat (3) @(negedge clk);
    peek(6'h01, d); chk("R6", "board temp pulse", d, 8'h10);
    smi_chain = 1'b1;
    repeat (4) @(negedge clk);
    smi_chain = 1'b0;
    peek(6'h01, d); chk("R6", "chain smi", d, 8'h18);
    clear_all();
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    meas(4'd2, 8'hc1);
    chk_out("R8", 1'b0, 1'b0);
    wr(6'h06, 8'h03); chk_out("R8", 1'b1, 1'b1);
    wr(6'h02, 8'h04); chk_out("R7", 1'b0, 1'b1);
    wr(6'h04, 8'h04); chk_out("R7", 1'b0, 1'b0);
    meas(4'd9, 8'h81); chk_out("R7", 1'b1, 1'b1);
    wr(6'h05, 8'h02); chk_out("R7", 1'b1, 1'b0);
    wr(6'h05, 8'h00);
    wr(6'h06, 8'h0b); chk_out("R8", 1'b1, 1'b0);
    wr(6'h06, 8'h0f); chk_out("R8", 1'b0, 1'b0);
    wr(6'h06, 8'h03);
    rd_clr(6'h01, d); chk_out("R7", 1'b0, 1'b0);
    wr(6'h02, 8'h00); chk_out("R7", 1'b1, 1'b0);
    wr(6'h04, 8'h00); wr(6'h06, 8'h00);
    clear_all();
  endtask

  task automatic t_ignore();
    logic [7:0] d;
    wr(6'h00, 8'hff); peek(6'h00, d); chk("R9", "status lo write", d, 8'h00);
    wr(6'h01, 8'hff); peek(6'h01, d); chk("R9", "status hi write", d, 8'h00);
    meas(4'd15, 8'h00); peek(6'h00, d); chk("R9", "slot 15 lo", d, 8'h00);
    peek(6'h01, d); chk("R9", "slot 15 hi", d, 8'h00);
    meas(4'd11, 8'hff); peek(6'h01, d); chk("R9", "slot 11 hi", d, 8'h00);
    wr(6'h03, 8'hff); peek(6'h03, d); chk("R9", "smi mask hi unused bits", d, 8'h3f);
    wr(6'h05, 8'hff); peek(6'h05, d); chk("R9", "nmi mask hi unused bits", d, 8'h3f);
    wr(6'h06, 8'hff); peek(6'h06, d); chk("R9", "ctrl unused bits", d, 8'h0f);
    peek(6'h3f, d); chk("R10", "unmapped", d, 8'h00);
    wr(6'h03, 8'h00); wr(6'h05, 8'h00); wr(6'h06, 8'h00);
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_volt();
    t_temp();
    t_fan();
    t_read_race();
    t_ext();
    t_outputs();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule